// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a ring of transmit buffer descriptors kept in system memory on behalf of a network transmitter. Each descriptor is two 32-bit words: the lower word is the byte address of a buffer, the upper word carries control and status. The walker reads descriptors through a synchronous single-port memory interface with one cycle of read latency. It presents each buffer's address, length, last-buffer flag and no-CRC flag to a downstream frame engine, then waits for that engine to finish the buffer. When a frame has gone out, it writes status back into the control word of the frame's first descriptor.

Software drives the walker through decoded strobes from its control register and its queue-base register. Start, halt and enable arrive as the three decoded bits of a control-register write. The frame engine reports collision, underrun and retry-limit events. A received pause with pause enabled holds the walker at the next frame boundary. A single run flag, visible in a status word, tells software whether the walker is active. Two kinds of stop recover the pointer differently. An error stop sends the pointer back to the queue base. Finding an owned descriptor at the head of a frame leaves the pointer in place, so the next start resumes at that descriptor.

Top module: `txdq_walker`

## Requirements
- R1: While `buf_valid` is high, `buf_addr` shows word 0 of the current descriptor, and `buf_len`, `buf_last` and `buf_nocrc` show word-1 bits 10:0, bit 15 and bit 16. All four hold steady until the engine answers with done, collision, underrun or retry.
- R2: A control write with enable and start set and halt clear sets the run flag (status bit 3) when the walker is idle. The same write while the walker is active has no effect on the buffer in flight.
- R3: If word-1 bit 31 (owned) is set on the first descriptor of a frame, the walker stops and clears the run flag, and nothing is written back. The next start fetches that same descriptor again.
- R4: After the done of a buffer whose last flag is set, word 1 of the frame's first descriptor is written back unchanged, except that bit 31 is set and bits 29:27 are cleared.
- R5: Word-1 bit 30 (wrap) on any completed buffer makes the next descriptor the one at the queue base.
- R6: After 1024 descriptors in a row without a wrap bit, the next descriptor is the one at the queue base.
- R7: A collision while a buffer is offered restarts the frame from its first descriptor.
- R8: An owned descriptor found after the first buffer of a frame counts as an error. `tx_err` and `bad_fcs` pulse for one cycle, and the write-back sets bits 31 and 29. The walker then stops with the pointer at the queue base.
- R9: An underrun sets write-back bit 28. A retry-limit event sets write-back bit 27. Either one pulses `tx_err` without `bad_fcs`, stops the walker and returns the pointer to the queue base.
- R10: A halt write does not end the current frame. The walker finishes the frame and its write-back, then stops before fetching the next frame.
- R11: A control write with enable clear stops the walker at once: `buf_valid` and the run flag drop on the next cycle, and the pointer returns to the queue base.
- R12: A queue-base write stops the walker at once and makes the written address the new queue base, with the pointer on it.
- R13: While pause is enabled and a pause is being received, the walker keeps the run flag set but offers no new frame. It continues when the pause clears.
- R14: During and after reset the run flag, `buf_valid`, `mem_req` and `tx_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_en | input | 1 | Written enable bit (control bit 3) |
| ctrl_start | input | 1 | Written start bit (control bit 9) |
| ctrl_halt | input | 1 | Written halt bit (control bit 10) |
| qptr_we | input | 1 | Queue-base register write strobe |
| qptr_wdata | input | AW | Queue-base byte address (low three bits ignored) |
| pause_en | input | 1 | Pause honouring enabled |
| pause_rx | input | 1 | Pause currently in force |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| buf_valid | output | 1 | Buffer offered to the frame engine |
| buf_addr | output | 32 | Buffer byte address |
| buf_len | output | LEN_W | Buffer length in bytes |
| buf_last | output | 1 | Buffer ends the frame |
| buf_nocrc | output | 1 | Frame is sent without appended CRC |
| buf_done | input | 1 | Engine finished the offered buffer |
| col_in | input | 1 | Collision during the offered buffer |
| underrun_in | input | 1 | Underrun during the offered buffer |
| retry_in | input | 1 | Retry limit reached |
| tx_err | output | 1 | One-cycle transmit error pulse |
| bad_fcs | output | 1 | Force a bad FCS on the aborted frame |
| status_word | output | 32 | Status register image, run flag at bit 3 |

## Verification
A wrong pointer shows up at the ports on the next fetch. Either an unexpected `buf_addr` appears four cycles after a start, or the walker stalls waiting on a descriptor nobody serves, so the bench judges pointer recovery by which buffer address comes out after each restart. A wrong first-descriptor record or error code shows up in the single write-back word, two cycles after the final done or the error event, and the bench reads that word from its memory model. A wrong stop decision appears within a few cycles as a run flag that stays high or drops too early.

// File: rtl/txdq_pkg.sv
package txdq_pkg;
   localparam int DW = 32;

   // descriptor word-1 bit positions
   localparam int W1_OWN     = 31;
   localparam int W1_WRAP    = 30;
   localparam int W1_ERR_MID = 29;
   localparam int W1_ERR_UND = 28;
   localparam int W1_ERR_RTY = 27;
   localparam int W1_NOCRC   = 16;
   localparam int W1_LAST    = 15;

   // status word bit position of the run flag
   localparam int STAT_RUN = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD1,
      ST_W1,
      ST_W0,
      ST_SEND,
      ST_WB
   } walk_st_e;

   typedef enum logic [1:0] {
      RC_HOLD,
      RC_STEP,
      RC_REWIND,
      RC_BASE
   } ring_cmd_e;

   typedef enum logic [1:0] {
      AS_CUR_W1,
      AS_CUR_W0,
      AS_FIRST_W1
   } addr_sel_e;

   typedef enum logic [1:0] {
      ERR_NONE,
      ERR_MID,
      ERR_UND,
      ERR_RTY
   } err_e;
endpackage

// File: rtl/txdq_ring.sv
module txdq_ring #(
   parameter int AW       = 32,
   parameter int RING_MAX = 1024
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 base_ld,
   input  logic [AW-1:0]        base_val,
   input  txdq_pkg::ring_cmd_e  cmd,
   input  logic                 wrap_in,
   input  logic                 mark_first,
   output logic [AW-1:0]        cur_addr,
   output logic [AW-1:0]        first_addr
);
   import txdq_pkg::*;

   localparam int IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;

   logic [AW-1:0]    base_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] fidx_q;
   logic [IDX_W-1:0] idx_step;

   // successor index without wrap bit: natural rollover or explicit compare
   generate
      if ((2 ** IDX_W) == RING_MAX) begin : g_pow2
         assign idx_step = idx_q + 1'b1;
      end else begin : g_cmp
         assign idx_step = (idx_q == IDX_W'(RING_MAX - 1)) ? '0 : idx_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
         fidx_q <= '0;
      end else if (base_ld) begin
         base_q <= base_val & ~AW'(7);
         idx_q  <= '0;
         fidx_q <= '0;
      end else begin
         unique case (cmd)
            RC_STEP:   idx_q <= wrap_in ? '0 : idx_step;
            RC_REWIND: idx_q <= fidx_q;
            RC_BASE:   idx_q <= '0;
            default:   idx_q <= idx_q;
         endcase
         if (mark_first) fidx_q <= idx_q;
      end
   end

   assign cur_addr   = base_q + (AW'(idx_q) << 3);
   assign first_addr = base_q + (AW'(fidx_q) << 3);
endmodule

// File: rtl/txdq_seq.sv
module txdq_seq #(
   parameter int LEN_W = 11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   go,
   input  logic                   kill,
   input  logic                   halt_req,
   input  logic                   pause_hold,
   input  logic [31:0]            mem_rdata,
   input  logic                   buf_done,
   input  logic                   col_in,
   input  logic                   underrun_in,
   input  logic                   retry_in,
   output logic                   mem_req,
   output logic                   mem_we,
   output txdq_pkg::addr_sel_e    addr_sel,
   output txdq_pkg::ring_cmd_e    ring_cmd,
   output logic                   mark_first,
   output logic                   wrap_out,
   output logic                   buf_valid,
   output logic [31:0]            buf_addr,
   output logic [LEN_W-1:0]       buf_len,
   output logic                   buf_last,
   output logic                   buf_nocrc,
   output logic [31:0]            first_w1,
   output txdq_pkg::err_e         err_code,
   output logic                   tx_err,
   output logic                   bad_fcs,
   output logic                   running
);
   import txdq_pkg::*;

   walk_st_e         st_q;
   logic             fstart_q;
   logic             halt_pend_q;
   err_e             err_q;
   logic [31:0]      w0_q;
   logic [LEN_W-1:0] len_q;
   logic             last_q;
   logic             nocrc_q;
   logic             wrap_q;

   logic head_stop;
   logic head_wait;
   logic owned;
   logic fail_evt;

   assign head_stop = fstart_q && (halt_pend_q || halt_req);
   assign head_wait = fstart_q && pause_hold;
   assign owned     = mem_rdata[W1_OWN];
   assign fail_evt  = underrun_in || retry_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         fstart_q    <= 1'b1;
         halt_pend_q <= 1'b0;
         err_q       <= ERR_NONE;
         w0_q        <= '0;
         len_q       <= '0;
         last_q      <= 1'b0;
         nocrc_q     <= 1'b0;
         wrap_q      <= 1'b0;
         first_w1    <= '0;
      end else if (kill) begin
         st_q        <= ST_IDLE;
         fstart_q    <= 1'b1;
         halt_pend_q <= 1'b0;
         err_q       <= ERR_NONE;
      end else begin
         if (halt_req && st_q != ST_IDLE) halt_pend_q <= 1'b1;
         unique case (st_q)
            ST_IDLE: begin
               if (go) begin
                  st_q        <= ST_RD1;
                  fstart_q    <= 1'b1;
                  halt_pend_q <= 1'b0;
                  err_q       <= ERR_NONE;
               end
            end
            ST_RD1: begin
               if (head_stop) begin
                  st_q        <= ST_IDLE;
                  halt_pend_q <= 1'b0;
               end else if (!head_wait) begin
                  st_q <= ST_W1;
               end
            end
            ST_W1: begin
               len_q   <= mem_rdata[LEN_W-1:0];
               last_q  <= mem_rdata[W1_LAST];
               nocrc_q <= mem_rdata[W1_NOCRC];
               wrap_q  <= mem_rdata[W1_WRAP];
               if (owned) begin
                  if (fstart_q) begin
                     st_q <= ST_IDLE;
                  end else begin
                     err_q <= ERR_MID;
                     st_q  <= ST_WB;
                  end
               end else begin
                  if (fstart_q) first_w1 <= mem_rdata;
                  st_q <= ST_W0;
               end
            end
            ST_W0: begin
               w0_q <= mem_rdata;
               st_q <= ST_SEND;
            end
            ST_SEND: begin
               if (col_in) begin
                  st_q     <= ST_RD1;
                  fstart_q <= 1'b1;
               end else if (underrun_in) begin
                  err_q <= ERR_UND;
                  st_q  <= ST_WB;
               end else if (retry_in) begin
                  err_q <= ERR_RTY;
                  st_q  <= ST_WB;
               end else if (buf_done) begin
                  if (last_q) begin
                     st_q <= ST_WB;
                  end else begin
                     st_q     <= ST_RD1;
                     fstart_q <= 1'b0;
                  end
               end
            end
            ST_WB: begin
               fstart_q <= 1'b1;
               if (err_q != ERR_NONE) begin
                  st_q  <= ST_IDLE;
                  err_q <= ERR_NONE;
               end else begin
                  st_q <= ST_RD1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req    = 1'b0;
      mem_we     = 1'b0;
      addr_sel   = AS_CUR_W1;
      ring_cmd   = RC_HOLD;
      mark_first = 1'b0;
      unique case (st_q)
         ST_RD1: begin
            mem_req    = !head_stop && !head_wait;
            mark_first = fstart_q;
         end
         ST_W1: begin
            mem_req  = !owned;
            addr_sel = AS_CUR_W0;
         end
         ST_SEND: begin
            if (col_in)                      ring_cmd = RC_REWIND;
            else if (!fail_evt && buf_done)  ring_cmd = RC_STEP;
         end
         ST_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            addr_sel = AS_FIRST_W1;
            if (err_q != ERR_NONE) ring_cmd = RC_BASE;
         end
         default: ;
      endcase
   end

   assign wrap_out  = wrap_q;
   assign buf_valid = (st_q == ST_SEND);
   assign buf_addr  = w0_q;
   assign buf_len   = len_q;
   assign buf_last  = last_q;
   assign buf_nocrc = nocrc_q;
   assign err_code  = err_q;
   assign tx_err    = (st_q == ST_WB) && (err_q != ERR_NONE);
   assign bad_fcs   = (st_q == ST_WB) && (err_q == ERR_MID);
   assign running   = (st_q != ST_IDLE);
endmodule

// File: rtl/txdq_wbfmt.sv
module txdq_wbfmt (
   input  logic [31:0]     first_w1,
   input  txdq_pkg::err_e  err_code,
   output logic [31:0]     wb_word
);
   import txdq_pkg::*;

   always_comb begin
      wb_word             = first_w1;
      wb_word[W1_OWN]     = 1'b1;
      wb_word[W1_ERR_MID] = (err_code == ERR_MID);
      wb_word[W1_ERR_UND] = (err_code == ERR_UND);
      wb_word[W1_ERR_RTY] = (err_code == ERR_RTY);
   end
endmodule

// File: rtl/txdq_walker.sv
module txdq_walker #(
   parameter int AW       = 32,
   parameter int LEN_W    = 11,
   parameter int RING_MAX = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             ctrl_en,
   input  logic             ctrl_start,
   input  logic             ctrl_halt,
   input  logic             qptr_we,
   input  logic [AW-1:0]    qptr_wdata,
   input  logic             pause_en,
   input  logic             pause_rx,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic [31:0]      mem_rdata,
   output logic             buf_valid,
   output logic [31:0]      buf_addr,
   output logic [LEN_W-1:0] buf_len,
   output logic             buf_last,
   output logic             buf_nocrc,
   input  logic             buf_done,
   input  logic             col_in,
   input  logic             underrun_in,
   input  logic             retry_in,
   output logic             tx_err,
   output logic             bad_fcs,
   output logic [31:0]      status_word
);
   import txdq_pkg::*;

   localparam int IDX_W = (RING_MAX > 1) ? $clog2(RING_MAX) : 1;

   generate
      if (RING_MAX < 2) begin : g_bad_ring
         $error("txdq_walker: RING_MAX must be at least 2");
      end
      if (AW < IDX_W + 3) begin : g_bad_aw
         $error("txdq_walker: AW too narrow for the ring");
      end
      if (LEN_W < 1 || LEN_W > W1_LAST) begin : g_bad_len
         $error("txdq_walker: LEN_W must fit below the last-buffer bit");
      end
   endgenerate

   logic       go;
   logic       kill;
   logic       halt_req;
   logic       pause_hold;
   logic       running;
   logic       mark_first;
   logic       wrap_bit;
   ring_cmd_e  seq_cmd;
   ring_cmd_e  ring_cmd;
   addr_sel_e  addr_sel;
   err_e       err_code;
   logic [31:0]   first_w1;
   logic [AW-1:0] cur_addr;
   logic [AW-1:0] first_addr;

   // control strobe decode; halt in the same write beats start
   assign kill       = (ctrl_we && !ctrl_en) || qptr_we;
   assign go         = ctrl_we && ctrl_en && ctrl_start && !ctrl_halt;
   assign halt_req   = ctrl_we && ctrl_en && ctrl_halt;
   assign pause_hold = pause_en && pause_rx;
   assign ring_cmd   = kill ? RC_BASE : seq_cmd;

   txdq_ring #(.AW(AW), .RING_MAX(RING_MAX)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_ld    (qptr_we),
      .base_val   (qptr_wdata),
      .cmd        (ring_cmd),
      .wrap_in    (wrap_bit),
      .mark_first (mark_first),
      .cur_addr   (cur_addr),
      .first_addr (first_addr)
   );

   txdq_seq #(.LEN_W(LEN_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go),
      .kill        (kill),
      .halt_req    (halt_req),
      .pause_hold  (pause_hold),
      .mem_rdata   (mem_rdata),
      .buf_done    (buf_done),
      .col_in      (col_in),
      .underrun_in (underrun_in),
      .retry_in    (retry_in),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .addr_sel    (addr_sel),
      .ring_cmd    (seq_cmd),
      .mark_first  (mark_first),
      .wrap_out    (wrap_bit),
      .buf_valid   (buf_valid),
      .buf_addr    (buf_addr),
      .buf_len     (buf_len),
      .buf_last    (buf_last),
      .buf_nocrc   (buf_nocrc),
      .first_w1    (first_w1),
      .err_code    (err_code),
      .tx_err      (tx_err),
      .bad_fcs     (bad_fcs),
      .running     (running)
   );

   txdq_wbfmt u_wbfmt (
      .first_w1 (first_w1),
      .err_code (err_code),
      .wb_word  (mem_wdata)
   );

   always_comb begin
      unique case (addr_sel)
         AS_CUR_W0:   mem_addr = cur_addr;
         AS_FIRST_W1: mem_addr = first_addr + AW'(4);
         default:     mem_addr = cur_addr + AW'(4);
      endcase
   end

   always_comb begin
      status_word           = '0;
      status_word[STAT_RUN] = running;
   end
endmodule

// File: rtl/txdq_walker_chk.sv
module txdq_walker_chk #(
   parameter int AW    = 32,
   parameter int LEN_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_we,
   input logic             ctrl_en,
   input logic             qptr_we,
   input logic             mem_we,
   input logic [31:0]      mem_wdata,
   input logic             buf_valid,
   input logic [31:0]      buf_addr,
   input logic [LEN_W-1:0] buf_len,
   input logic             buf_done,
   input logic             col_in,
   input logic             underrun_in,
   input logic             retry_in,
   input logic             tx_err,
   input logic             bad_fcs,
   input logic [31:0]      status_word
);
   // R1
   buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !buf_done && !col_in && !underrun_in && !retry_in && !ctrl_we && !qptr_we)
      |=> (buf_valid && $stable(buf_addr) && $stable(buf_len)));

   // R2
   offer_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |-> status_word[3]);

   // R4
   wb_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata[31]);

   // R8
   fcs_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_fcs |-> (tx_err && mem_wdata[29]));

   // R9
   err_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err |-> mem_we);

   // R11
   disable_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !ctrl_en) |=> (!buf_valid && !status_word[3]));

   // R12
   qptr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qptr_we |=> !status_word[3]);
endmodule

bind txdq_walker txdq_walker_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_we     (ctrl_we),
   .ctrl_en     (ctrl_en),
   .qptr_we     (qptr_we),
   .mem_we      (mem_we),
   .mem_wdata   (mem_wdata),
   .buf_valid   (buf_valid),
   .buf_addr    (buf_addr),
   .buf_len     (buf_len),
   .buf_done    (buf_done),
   .col_in      (col_in),
   .underrun_in (underrun_in),
   .retry_in    (retry_in),
   .tx_err      (tx_err),
   .bad_fcs     (bad_fcs),
   .status_word (status_word)
);

// File: tb/tb_txdq_walker.sv
module tb_txdq_walker;
   localparam int AW    = 32;
   localparam int LEN_W = 11;
   localparam int MEMW  = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic ctrl_we = 0, ctrl_en = 0, ctrl_start = 0, ctrl_halt = 0;
   logic qptr_we = 0;
   logic [AW-1:0] qptr_wdata = '0;
   logic pause_en = 0, pause_rx = 0;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic buf_valid, buf_last, buf_nocrc;
   logic [31:0] buf_addr;
   logic [LEN_W-1:0] buf_len;
   logic buf_done = 0, col_in = 0, underrun_in = 0, retry_in = 0;
   logic tx_err, bad_fcs;
   logic [31:0] status_word;

   txdq_walker #(.AW(AW), .LEN_W(LEN_W), .RING_MAX(1024)) dut (.*);

   // memory model with a bench write port and a bulk clear
   logic [31:0] mem [0:MEMW-1];
   logic        tb_we = 0, tb_clr = 0;
   int          tb_idx = 0;
   logic [31:0] tb_wd = '0;
   always @(posedge clk) begin
      if (tb_clr) begin
         for (int k = 0; k < MEMW; k++) mem[k] <= (k % 2 == 1) ? 32'h8000_0000 : 32'hDEAD_0000 + k;
      end else if (tb_we) begin
         mem[tb_idx] <= tb_wd;
      end else if (mem_req && mem_we) begin
         mem[mem_addr[13:2]] <= mem_wdata;
      end
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
   end

   int checks = 0, errors = 0;
   int txerr_cnt = 0, fcs_cnt = 0, vld_cnt = 0;
   logic [31:0] seen_addr;
   bit done_flag = 0;

   always @(posedge clk) if (rst_n) begin
      if (tx_err)    txerr_cnt++;
      if (bad_fcs)   fcs_cnt++;
      if (buf_valid) vld_cnt++;
   end

   function automatic logic [31:0] w1(bit own, bit wrap, bit last, bit nocrc, int len);
      logic [31:0] w = '0;
      w[31] = own; w[30] = wrap; w[15] = last; w[16] = nocrc;
      w[10:0] = len[10:0];
      return w;
   endfunction

   task automatic chk_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic poke(int idx, logic [31:0] d);
      @(negedge clk); tb_we = 1; tb_idx = idx; tb_wd = d;
      @(posedge clk); #1 tb_we = 0;
   endtask

   task automatic clear_mem();
      @(negedge clk); tb_clr = 1;
      @(posedge clk); #1 tb_clr = 0;
   endtask

   task automatic ctrl_write(bit en, bit start, bit halt);
      @(negedge clk); ctrl_we = 1; ctrl_en = en; ctrl_start = start; ctrl_halt = halt;
      @(negedge clk); ctrl_we = 0; ctrl_start = 0; ctrl_halt = 0;
   endtask

   task automatic qptr_write(logic [31:0] a);
      @(negedge clk); qptr_we = 1; qptr_wdata = a;
      @(negedge clk); qptr_we = 0;
   endtask

   task automatic wait_valid(output bit got);
      got = 0;
      for (int t = 0; t < 200; t++) begin
         @(negedge clk);
         if (buf_valid) begin got = 1; break; end
      end
      seen_addr = got ? buf_addr : 32'hFFFF_FFFF;
   endtask

   task automatic grab(output bit got);
      wait_valid(got);
      if (got) begin
         buf_done = 1;
         @(negedge clk); buf_done = 0;
      end
   endtask

   task automatic serve(string req, logic [31:0] exp);
      bit got;
      grab(got);
      chk_eq(req, "buffer address", seen_addr, exp);
   endtask

   task automatic wait_idle(string req);
      bit idle = 0;
      for (int t = 0; t < 300; t++) begin
         @(negedge clk);
         if (!status_word[3]) begin idle = 1; break; end
      end
      chk_eq(req, "walker stopped", 32'(idle), 32'd1);
   endtask

   task automatic pulse(int which);
      case (which)
         0: col_in = 1;
         1: underrun_in = 1;
         default: retry_in = 1;
      endcase
      @(negedge clk); col_in = 0; underrun_in = 0; retry_in = 0;
   endtask

   // table: {buffer address, no-CRC flag, length}
   localparam int NV = 6;
   localparam logic [43:0] VEC [NV] = '{
      {32'h0000_1000, 1'b0, 11'd64},
      {32'h0000_2004, 1'b1, 11'd1},
      {32'hABCD_0000, 1'b0, 11'd2047},
      {32'h1234_5678, 1'b1, 11'd1518},
      {32'h0000_0000, 1'b0, 11'd0},
      {32'hFFFF_FFFC, 1'b1, 11'd1024}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      bit got;
      int e0, f0, mism;
      logic [31:0] w;

      // R14 reset state
      repeat (3) @(negedge clk);
      chk_eq("R14", "run flag in reset", 32'(status_word[3]), 0);
      chk_eq("R14", "buf_valid in reset", 32'(buf_valid), 0);
      rst_n = 1;
      @(negedge clk);
      chk_eq("R14", "mem_req after reset", 32'(mem_req), 0);
      chk_eq("R14", "tx_err after reset", 32'(tx_err), 0);

      clear_mem();
      qptr_write(32'h0);

      // table walk: R1 fields, R4 write-back, R3 stop and resume in place
      for (int i = 0; i < NV; i++) begin
         w = w1(0, 0, 1, VEC[i][11], int'(VEC[i][10:0]));
         poke(2*i, VEC[i][43:12]);
         poke(2*i+1, w);
         ctrl_write(1, 1, 0);
         chk_eq("R2", "run flag after start", 32'(status_word[3]), 1);
         wait_valid(got);
         chk_eq("R1", "address", seen_addr, VEC[i][43:12]);
         chk_eq("R1", "length", 32'(buf_len), 32'(VEC[i][10:0]));
         chk_eq("R1", "no-CRC flag", 32'(buf_nocrc), 32'(VEC[i][11]));
         chk_eq("R1", "last flag", 32'(buf_last), 1);
         buf_done = 1; @(negedge clk); buf_done = 0;
         wait_idle("R3");
         chk_eq("R4", "write-back word", mem[2*i+1], w | 32'h8000_0000);
      end

      // R2 start rewritten while active
      poke(12, 32'h0000_7000); poke(13, w1(0, 0, 1, 0, 100));
      ctrl_write(1, 1, 0);
      wait_valid(got);
      ctrl_write(1, 1, 0);
      chk_eq("R2", "offer kept after restart write", {buf_valid, 31'(buf_addr >> 1)}, {1'b1, 31'(32'h0000_7000 >> 1)});
      serve("R2", 32'h0000_7000);
      wait_idle("R2");

      // R5 wrap bit
      clear_mem(); qptr_write(32'h100);
      poke(64, 32'hA0); poke(65, w1(0, 0, 0, 0, 10));
      poke(66, 32'hA1); poke(67, w1(0, 1, 1, 0, 10));
      poke(68, 32'hA2); poke(69, w1(0, 0, 1, 0, 10));
      ctrl_write(1, 1, 0);
      serve("R5", 32'hA0); serve("R5", 32'hA1);
      wait_idle("R5");
      chk_eq("R5", "descriptor after wrap untouched", mem[69], w1(0, 0, 1, 0, 10));
      chk_eq("R4", "multi-buffer write-back on first", mem[65], w1(1, 0, 0, 0, 10));

      // R7 collision restarts frame
      clear_mem(); qptr_write(32'h0);
      poke(0, 32'hB0); poke(1, w1(0, 0, 0, 0, 5));
      poke(2, 32'hB1); poke(3, w1(0, 0, 1, 0, 5));
      ctrl_write(1, 1, 0);
      serve("R7", 32'hB0);
      wait_valid(got);
      chk_eq("R7", "second buffer", seen_addr, 32'hB1);
      pulse(0);
      serve("R7", 32'hB0);
      serve("R7", 32'hB1);
      wait_idle("R7");
      chk_eq("R7", "write-back after restart", mem[1], w1(1, 0, 0, 0, 5));

      // R8 owned descriptor mid-frame
      clear_mem(); qptr_write(32'h0);
      e0 = txerr_cnt; f0 = fcs_cnt;
      poke(0, 32'hC0); poke(1, w1(0, 0, 0, 1, 7));
      ctrl_write(1, 1, 0);
      serve("R8", 32'hC0);
      wait_idle("R8");
      chk_eq("R8", "tx_err pulses", 32'(txerr_cnt - e0), 1);
      chk_eq("R8", "bad_fcs pulses", 32'(fcs_cnt - f0), 1);
      chk_eq("R8", "write-back", mem[1], w1(1, 0, 0, 1, 7) | 32'h2000_0000);
      poke(0, 32'hC8); poke(1, w1(0, 0, 1, 0, 7));
      ctrl_write(1, 1, 0);
      serve("R8", 32'hC8);
      wait_idle("R8");

      // R9 underrun on second frame, pointer back to base
      clear_mem(); qptr_write(32'h0);
      e0 = txerr_cnt; f0 = fcs_cnt;
      poke(0, 32'hD0); poke(1, w1(0, 0, 1, 0, 3));
      poke(2, 32'hD1); poke(3, w1(0, 0, 1, 0, 4));
      ctrl_write(1, 1, 0);
      serve("R9", 32'hD0);
      wait_valid(got);
      pulse(1);
      wait_idle("R9");
      chk_eq("R9", "underrun write-back", mem[3], w1(1, 0, 1, 0, 4) | 32'h1000_0000);
      chk_eq("R9", "error pulses without bad FCS", {16'(txerr_cnt - e0), 16'(fcs_cnt - f0)}, {16'd1, 16'd0});
      poke(0, 32'hD8); poke(1, w1(0, 0, 1, 0, 3));
      ctrl_write(1, 1, 0);
      serve("R9", 32'hD8);
      wait_idle("R9");

      // R9 retry limit
      clear_mem(); qptr_write(32'h0);
      poke(0, 32'hE0); poke(1, w1(0, 0, 1, 1, 9));
      ctrl_write(1, 1, 0);
      wait_valid(got);
      pulse(2);
      wait_idle("R9");
      chk_eq("R9", "retry write-back", mem[1], w1(1, 0, 1, 1, 9) | 32'h0800_0000);

      // R10 halt completes frame
      clear_mem(); qptr_write(32'h0);
      poke(0, 32'hF0); poke(1, w1(0, 0, 0, 0, 8));
      poke(2, 32'hF1); poke(3, w1(0, 0, 1, 0, 8));
      poke(4, 32'hF2); poke(5, w1(0, 0, 1, 0, 8));
      ctrl_write(1, 1, 0);
      wait_valid(got);
      ctrl_write(1, 0, 1);
      chk_eq("R10", "frame continues after halt", {31'd0, buf_valid & status_word[3]}, 1);
      serve("R10", 32'hF0); serve("R10", 32'hF1);
      wait_idle("R10");
      chk_eq("R10", "frame written back", mem[1], w1(1, 0, 0, 0, 8));
      chk_eq("R10", "next frame not taken", mem[5], w1(0, 0, 1, 0, 8));

      // R11 disable stops at once and rewinds
      clear_mem(); qptr_write(32'h0);
      poke(0, 32'h10); poke(1, w1(0, 0, 1, 0, 2));
      poke(2, 32'h11); poke(3, w1(0, 0, 1, 0, 2));
      ctrl_write(1, 1, 0);
      serve("R11", 32'h10);
      wait_valid(got);
      ctrl_write(0, 0, 0);
      chk_eq("R11", "offer and run dropped", {buf_valid, status_word[3]}, 0);
      e0 = vld_cnt;
      ctrl_write(1, 1, 0);
      wait_idle("R11");
      chk_eq("R11", "restart hits owned base", 32'(vld_cnt - e0), 0);

      // R12 queue-base write
      clear_mem(); qptr_write(32'h0);
      poke(0, 32'h20); poke(1, w1(0, 0, 1, 0, 2));
      ctrl_write(1, 1, 0);
      wait_valid(got);
      qptr_write(32'h800);
      chk_eq("R12", "stopped by base write", {buf_valid, status_word[3]}, 0);
      poke(512, 32'h21); poke(513, w1(0, 0, 1, 0, 2));
      ctrl_write(1, 1, 0);
      serve("R12", 32'h21);
      wait_idle("R12");

      // R13 pause
      clear_mem(); qptr_write(32'h0);
      poke(0, 32'h30); poke(1, w1(0, 0, 1, 0, 2));
      pause_en = 1; pause_rx = 1;
      ctrl_write(1, 1, 0);
      repeat (20) @(negedge clk);
      chk_eq("R13", "held while paused", {buf_valid, status_word[3]}, 1);
      pause_rx = 0;
      serve("R13", 32'h30);
      wait_idle("R13");
      pause_en = 0;

      // R6 rollover after 1024 descriptors
      clear_mem(); qptr_write(32'h0);
      for (int i = 0; i < 1024; i++) begin
         poke(2*i, 32'h4000_0000 + i);
         poke(2*i+1, w1(0, 0, 1, 0, 1));
      end
      ctrl_write(1, 1, 0);
      mism = 0;
      for (int i = 0; i < 1024; i++) begin
         grab(got);
         if (seen_addr !== 32'h4000_0000 + i) mism++;
      end
      wait_idle("R6");
      chk_eq("R6", "addresses walked", 32'(mism), 0);
      poke(0, 32'h5555_0000); poke(1, w1(0, 0, 1, 0, 1));
      ctrl_write(1, 1, 0);
      serve("R6", 32'h5555_0000);
      wait_idle("R6");

      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule